// File: doc/BRIEF.md
# Prioritized Contention Access Controller

This block is the channel access engine of a wireless station. While traffic is waiting it runs ordinary slotted random backoff: it waits out a fixed arbitration period of idle slots, counts a random backoff down on further idle slots, and then strobes the transmitter. The transmitter reports whether the attempt succeeded, and the contention window grows or shrinks from that report.

After a configured number of consecutive failed attempts the controller switches to a priority mode. At the first idle slot of every contention period it then asks for a short defer signal, which carries a duration and the station address, and only then arbitrates and counts down. A station in normal mode that hears someone else's defer signal leaves the current contention period and comes back only when the medium has gone busy and then idle again, with its remaining backoff kept. A station in priority mode ignores received defer signals, because several priority stations sending the same signal together is the expected case and not a collision. One successful attempt returns the controller to normal mode.

The state machine has six states. IDLE draws a backoff value when traffic appears and goes to DS_SEND in priority mode, otherwise to ARB. DS_SEND requests the defer signal on the first idle slot and goes to ARB. ARB counts arbitration slots and goes to COUNT. COUNT decrements the backoff and goes to TX_WAIT when it fires. TX_WAIT returns to IDLE on the outcome report. EXCLUDED is entered from ARB or COUNT when a defer signal is received in normal mode, and it leaves for ARB on a rising medium-idle edge. A busy medium sends ARB and COUNT back to ARB in normal mode and to DS_SEND in priority mode.

Top module: `prio_access_ctrl`

## Requirements
- R1: After reset `tx_start`, `ds_req` and `prio_mode` are 0, and the contention window is CW_MIN (15).
- R2: With an idle medium, `tx_start` pulses for one cycle after the slot tick numbered AIFSN + B + 1 (or AIFSN + B + 2 in priority mode), where B = `rand_val` AND window is sampled on the cycle IDLE sees `traffic_pending`.
- R3: A busy medium during ARB or COUNT restarts the AIFSN-slot arbitration wait and keeps the remaining backoff count, with no new draw.
- R4: A failed outcome (`tx_done`=1, `tx_ok`=0) sets the window to 2·window+1, saturating at CW_MAX (1023).
- R5: A successful outcome (`tx_done`=1, `tx_ok`=1) resets the window to CW_MIN.
- R6: `prio_mode` rises in the cycle after the outcome that completes FAIL_LIMIT (default 1) consecutive failures.
- R7: In priority mode `ds_req` pulses for one cycle on the first idle slot of each contention period, before any arbitration slot, with `ds_duration` = DS_DUR and `ds_ta` = STA_ADDR during the pulse. A busy medium opens a new period and so produces a new request. `ds_req` is never 1 in normal mode.
- R8: In normal mode a `ds_rx` pulse during ARB or COUNT stops all counting until `medium_idle` rises again, and the backoff remaining at that point is kept.
- R9: In priority mode `ds_rx` has no effect: it changes neither the timing nor the failure count.
- R10: A successful outcome in priority mode clears `prio_mode` in the next cycle, and the next attempt sends no defer signal.
- R11: Without `traffic_pending` the block produces neither `tx_start` nor `ds_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| traffic_pending | input | 1 | Traffic is waiting to be sent |
| medium_idle | input | 1 | Carrier sense reports an idle medium |
| slot_tick | input | 1 | One-cycle pulse at each slot boundary |
| ds_rx | input | 1 | A defer signal from another station was received |
| tx_done | input | 1 | Outcome report strobe |
| tx_ok | input | 1 | Outcome, valid with tx_done: 1 = success |
| rand_val | input | CW_W | Random source, masked by the window |
| ds_req | output | 1 | Request to send the defer signal |
| ds_duration | output | DUR_W | Duration field for the defer signal |
| ds_ta | output | ADDR_W | Transmitter address for the defer signal |
| tx_start | output | 1 | Strobe that starts a transmission |
| prio_mode | output | 1 | The controller is in priority mode |

## Verification
Directed runs cover three cases. A chain of forced failures with an all-ones random source shows the window doubling and saturating, because each tx_start delay equals the window. An exclusion run places a received defer signal in the middle of a countdown and tells a preserved backoff apart from a redrawn one. A priority run with a defer signal received on every slot separates R9 from the exclusion in R8. Random attempts then draw the random value, the slot index of a single busy event and the outcome, and compare the slot count to tx_start and the number of defer requests with a reference function. That comparison separates a wait restarted in arbitration from a frozen countdown, and a first-slot busy event in priority mode from a later one.

// File: rtl/pca_pkg.sv
package pca_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DS_SEND,
        ST_ARB,
        ST_COUNT,
        ST_TX_WAIT,
        ST_EXCLUDED
    } pca_state_e;
endpackage

// File: rtl/pca_cw.sv
module pca_cw #(
    parameter int CW_MIN = 15,
    parameter int CW_MAX = 1023,
    parameter int CW_W   = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            win,
    input  logic            lose,
    output logic [CW_W-1:0] cw
);
    logic [CW_W:0] grown;

    assign grown = {cw, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cw <= CW_W'(CW_MIN);
        end else if (win) begin
            cw <= CW_W'(CW_MIN);
        end else if (lose) begin
            if (grown > (CW_W+1)'(CW_MAX))
                cw <= CW_W'(CW_MAX);
            else
                cw <= grown[CW_W-1:0];
        end
    end
endmodule

// File: rtl/pca_prio.sv
module pca_prio #(
    parameter int FAIL_LIMIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic win,
    input  logic lose,
    output logic prio
);
    generate
        if (FAIL_LIMIT <= 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n)    prio <= 1'b0;
                else if (win)  prio <= 1'b0;
                else if (lose) prio <= 1'b1;
            end
        end else begin : g_count
            localparam int FC_W = $clog2(FAIL_LIMIT + 1);
            logic [FC_W-1:0] fails_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    fails_q <= '0;
                    prio    <= 1'b0;
                end else if (win) begin
                    fails_q <= '0;
                    prio    <= 1'b0;
                end else if (lose) begin
                    if (fails_q < FC_W'(FAIL_LIMIT))
                        fails_q <= fails_q + 1'b1;
                    if (fails_q >= FC_W'(FAIL_LIMIT - 1))
                        prio <= 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pca_backoff.sv
module pca_backoff #(
    parameter int CW_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CW_W-1:0] load_val,
    input  logic            dec,
    output logic            zero
);
    logic [CW_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load)   cnt_q <= load_val;
        else if (dec)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/prio_access_ctrl.sv
module prio_access_ctrl #(
    parameter int          CW_MIN     = 15,
    parameter int          CW_MAX     = 1023,
    parameter int          AIFSN      = 2,
    parameter int          FAIL_LIMIT = 1,
    parameter int          DUR_W      = 16,
    parameter int          ADDR_W     = 48,
    parameter logic [15:0] DS_DUR     = 16'h0040,
    parameter logic [47:0] STA_ADDR   = 48'h0200_0000_0001,
    parameter int          CW_W       = $clog2(CW_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              traffic_pending,
    input  logic              medium_idle,
    input  logic              slot_tick,
    input  logic              ds_rx,
    input  logic              tx_done,
    input  logic              tx_ok,
    input  logic [CW_W-1:0]   rand_val,
    output logic              ds_req,
    output logic [DUR_W-1:0]  ds_duration,
    output logic [ADDR_W-1:0] ds_ta,
    output logic              tx_start,
    output logic              prio_mode
);
    import pca_pkg::*;

    localparam int AIFS_W = $clog2(AIFSN + 1);

    pca_state_e      state_q, state_d;
    logic [AIFS_W-1:0] aifs_q;
    logic            idle_q;
    logic            aifs_clr, aifs_inc;
    logic            bo_load, bo_dec, bo_zero;
    logic            tx_fire, ds_fire;
    logic            win, lose;
    logic [CW_W-1:0] cw_q;

    assign win  = (state_q == ST_TX_WAIT) && tx_done &&  tx_ok;
    assign lose = (state_q == ST_TX_WAIT) && tx_done && !tx_ok;

    pca_cw #(.CW_MIN(CW_MIN), .CW_MAX(CW_MAX), .CW_W(CW_W)) u_cw (
        .clk(clk), .rst_n(rst_n), .win(win), .lose(lose), .cw(cw_q)
    );

    pca_prio #(.FAIL_LIMIT(FAIL_LIMIT)) u_prio (
        .clk(clk), .rst_n(rst_n), .win(win), .lose(lose), .prio(prio_mode)
    );

    pca_backoff #(.CW_W(CW_W)) u_bo (
        .clk(clk), .rst_n(rst_n), .load(bo_load), .load_val(rand_val & cw_q),
        .dec(bo_dec), .zero(bo_zero)
    );

    always_comb begin
        state_d  = state_q;
        aifs_clr = 1'b0;
        aifs_inc = 1'b0;
        bo_load  = 1'b0;
        bo_dec   = 1'b0;
        tx_fire  = 1'b0;
        ds_fire  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (traffic_pending) begin
                    bo_load  = 1'b1;
                    aifs_clr = 1'b1;
                    state_d  = prio_mode ? ST_DS_SEND : ST_ARB;
                end
            end
            ST_DS_SEND: begin
                if (slot_tick && medium_idle) begin
                    ds_fire  = 1'b1;
                    aifs_clr = 1'b1;
                    state_d  = ST_ARB;
                end
            end
            ST_ARB: begin
                if (ds_rx && !prio_mode) begin
                    state_d = ST_EXCLUDED;
                end else if (!medium_idle) begin
                    aifs_clr = 1'b1;
                    state_d  = prio_mode ? ST_DS_SEND : ST_ARB;
                end else if (slot_tick) begin
                    if (aifs_q == AIFS_W'(AIFSN - 1)) state_d = ST_COUNT;
                    else                              aifs_inc = 1'b1;
                end
            end
            ST_COUNT: begin
                if (ds_rx && !prio_mode) begin
                    state_d = ST_EXCLUDED;
                end else if (!medium_idle) begin
                    aifs_clr = 1'b1;
                    state_d  = prio_mode ? ST_DS_SEND : ST_ARB;
                end else if (slot_tick) begin
                    if (bo_zero) begin
                        tx_fire = 1'b1;
                        state_d = ST_TX_WAIT;
                    end else begin
                        bo_dec = 1'b1;
                    end
                end
            end
            ST_TX_WAIT: begin
                if (tx_done) state_d = ST_IDLE;
            end
            ST_EXCLUDED: begin
                if (medium_idle && !idle_q) begin
                    aifs_clr = 1'b1;
                    state_d  = ST_ARB;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            aifs_q  <= '0;
            idle_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            idle_q  <= medium_idle;
            if (aifs_clr)      aifs_q <= '0;
            else if (aifs_inc) aifs_q <= aifs_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_start <= 1'b0;
            ds_req   <= 1'b0;
        end else begin
            tx_start <= tx_fire;
            ds_req   <= ds_fire;
        end
    end

    assign ds_duration = ds_req ? DUR_W'(DS_DUR)    : '0;
    assign ds_ta       = ds_req ? ADDR_W'(STA_ADDR) : '0;
endmodule

// File: rtl/pca_checker.sv
module pca_checker #(
    parameter int          CW_MIN = 15,
    parameter int          CW_MAX = 1023,
    parameter int          CW_W   = 10,
    parameter int          DUR_W  = 16,
    parameter logic [15:0] DS_DUR = 16'h0040
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_done,
    input logic             tx_ok,
    input logic             tx_start,
    input logic             ds_req,
    input logic             prio_mode,
    input logic [DUR_W-1:0] ds_duration,
    input logic [CW_W-1:0]  cw
);
    p_tx_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_start, ds_req}));

    p_ds_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req |=> !ds_req);

    p_ds_in_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req |-> prio_mode);

    p_ds_dur_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req |-> (ds_duration == DUR_W'(DS_DUR)));

    p_cw_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cw >= CW_W'(CW_MIN)) && (cw <= CW_W'(CW_MAX)));

    p_prio_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prio_mode) |-> $past(tx_done && !tx_ok));

    p_prio_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prio_mode) |-> $past(tx_done && tx_ok));
endmodule

bind prio_access_ctrl pca_checker #(
    .CW_MIN(CW_MIN), .CW_MAX(CW_MAX), .CW_W(CW_W), .DUR_W(DUR_W), .DS_DUR(DS_DUR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .tx_ok(tx_ok),
    .tx_start(tx_start), .ds_req(ds_req), .prio_mode(prio_mode),
    .ds_duration(ds_duration), .cw(cw_q)
);

// File: tb/prio_access_ctrl_bench.sv
module prio_access_ctrl_bench;
    localparam int          AIFSN    = 2;
    localparam int          CW_W     = 10;
    localparam logic [15:0] DS_DUR   = 16'h0040;
    localparam logic [47:0] STA_ADDR = 48'h0200_0000_0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic traffic_pending = 1'b0, medium_idle = 1'b1, slot_tick = 1'b0;
    logic ds_rx = 1'b0, tx_done = 1'b0, tx_ok = 1'b0;
    logic [CW_W-1:0] rand_val = '0;
    logic ds_req, tx_start, prio_mode;
    logic [15:0] ds_duration;
    logic [47:0] ds_ta;

    int n_tests = 0, n_fail = 0;
    int tx_cnt = 0, ds_cnt = 0;
    int cw_m = 15;
    bit prio_m = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    prio_access_ctrl u_prio_access_ctrl (
        .clk(clk), .rst_n(rst_n), .traffic_pending(traffic_pending),
        .medium_idle(medium_idle), .slot_tick(slot_tick), .ds_rx(ds_rx),
        .tx_done(tx_done), .tx_ok(tx_ok), .rand_val(rand_val),
        .ds_req(ds_req), .ds_duration(ds_duration), .ds_ta(ds_ta),
        .tx_start(tx_start), .prio_mode(prio_mode)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_ticks(input bit prio, input int b, input int k);
        int n0, kp, d;
        n0 = (prio ? 1 : 0) + AIFSN + b + 1;
        if (k < 0) return n0;
        if (!prio) begin
            if (k < AIFSN) return k + AIFSN + b + 1;
            return k + AIFSN + (b - (k - AIFSN)) + 1;
        end
        if (k == 0) return n0;
        kp = k - 1;
        d = (kp > AIFSN) ? kp - AIFSN : 0;
        return k + 1 + AIFSN + (b - d) + 1;
    endfunction

    task automatic slot(input bit idle, input bit ds);
        @(negedge clk);
        slot_tick = 1'b1; medium_idle = idle; ds_rx = ds;
        @(posedge clk); #1;
        if (tx_start) tx_cnt++;
        if (ds_req) begin
            ds_cnt++;
            chk(ds_duration == DS_DUR && ds_ta == STA_ADDR, "R7 fields",
                longint'(ds_duration), longint'(DS_DUR));
        end
        @(negedge clk);
        slot_tick = 1'b0; ds_rx = 1'b0; medium_idle = 1'b1;
    endtask

    task automatic outcome(input bit ok);
        @(negedge clk);
        tx_done = 1'b1; tx_ok = ok; traffic_pending = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        tx_done = 1'b0;
        if (ok) begin
            cw_m = 15; prio_m = 1'b0;
        end else begin
            cw_m = (2*cw_m + 1 > 1023) ? 1023 : 2*cw_m + 1;
            prio_m = 1'b1;
        end
        chk(prio_mode == prio_m, ok ? "R10 prio after success" : "R6 prio after failure",
            prio_mode, prio_m);
    endtask

    task automatic attempt(input logic [CW_W-1:0] rv, input int k, input bit ds_each,
                           input bit ok, input string tag);
        int b, expn, expds, n;
        bit busy_done;
        b = int'(rv) & cw_m;
        expn = exp_ticks(prio_m, b, k);
        expds = prio_m ? ((k >= 1) ? 2 : 1) : 0;
        @(negedge clk);
        rand_val = rv; traffic_pending = 1'b1;
        tx_cnt = 0; ds_cnt = 0; n = 0; busy_done = 1'b0;
        while (tx_cnt == 0 && n < 4000) begin
            if (n == k && !busy_done) begin
                slot(1'b0, ds_each);
                busy_done = 1'b1;
            end else begin
                slot(1'b1, ds_each);
                n++;
            end
        end
        chk(n == expn, tag, n, expn);
        chk(ds_cnt == expds, "R7 defer request count", ds_cnt, expds);
        outcome(ok);
    endtask

    initial begin
        int rv, k;
        bit ok;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk(!tx_start && !ds_req && !prio_mode, "R1 reset outputs",
            {tx_start, ds_req, prio_mode}, 0);

        // R11: no traffic, no strobes
        tx_cnt = 0; ds_cnt = 0;
        repeat (8) slot(1'b1, 1'b0);
        chk(tx_cnt == 0 && ds_cnt == 0, "R11 quiet without traffic", tx_cnt + ds_cnt, 0);

        // R1/R2: first draw uses window 15 (rand all ones -> B=15)
        attempt(10'h3FF, -1, 1'b0, 1'b0, "R1 R2 initial window timing");
        // R4: doubling chain with saturation; priority mode after first failure
        for (int i = 0; i < 6; i++) attempt(10'h3FF, -1, 1'b0, 1'b0, "R4 window doubling");
        chk(cw_m == 1023, "R4 saturation model", cw_m, 1023);
        attempt(10'h3FF, -1, 1'b0, 1'b1, "R4 window held at max");
        // R5/R10: success restores window 15 and normal mode
        attempt(10'h3FF, -1, 1'b0, 1'b1, "R5 window back to minimum");

        // R8: exclusion by a received defer signal, backoff preserved
        @(negedge clk);
        rand_val = 10'd5; traffic_pending = 1'b1;
        tx_cnt = 0; ds_cnt = 0;
        repeat (3) slot(1'b1, 1'b0);
        slot(1'b1, 1'b1);
        repeat (10) slot(1'b1, 1'b0);
        chk(tx_cnt == 0, "R8 no transmit while excluded", tx_cnt, 0);
        slot(1'b0, 1'b0);
        begin
            int n = 0;
            while (tx_cnt == 0 && n < 100) begin slot(1'b1, 1'b0); n++; end
            chk(n == AIFSN + 4 + 1, "R8 resume with kept backoff", n, AIFSN + 5);
        end
        outcome(1'b1);

        // R9: priority station ignores defer signals from others
        attempt(10'd3, -1, 1'b0, 1'b0, "R2 attempt before priority");
        attempt(10'd6, -1, 1'b1, 1'b1, "R9 ds_rx ignored in priority mode");
        attempt(10'd2, -1, 1'b0, 1'b1, "R10 no defer after exit");

        // R3: busy during arbitration vs countdown, directed
        attempt(10'd7, 1, 1'b0, 1'b1, "R3 busy during arbitration");
        attempt(10'd7, 5, 1'b0, 1'b0, "R3 busy during countdown");
        attempt(10'd7, 0, 1'b0, 1'b0, "R7 busy before defer sent");
        attempt(10'd7, 4, 1'b0, 1'b1, "R7 busy after defer sent");

        // constrained random attempts
        void'($urandom(32'd1234));
        for (int i = 0; i < 24; i++) begin
            int b;
            rv = int'($urandom_range(0, 1023));
            b = rv & cw_m;
            k = int'($urandom_range(0, 3)) == 0 ? -1
                : int'($urandom_range(0, (prio_m ? 1 : 0) + AIFSN + b));
            ok = ($urandom_range(0, 9) < 6);
            attempt(rv[CW_W-1:0], k, prio_m & ($urandom_range(0, 1) == 1), ok,
                    "R2 R3 random attempt");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule